// File: doc/BRIEF.md
# Per-Destination Acknowledgement Tracker for a Single Edge Line

This block follows one edge-triggered interrupt line whose deliveries must not pile up unseen. When the line is sent out, the block stores which destinations accepted it as a bitmap. It also keeps a counter of acknowledgements still owed. While anything is still owed, a new assertion of the line is reported as coalesced, so the caller can skip the delivery and keep track of how many were lost.

Each destination returns an end-of-interrupt message tagged with its index, and that message retires the destination's share. A restore port rebuilds the bitmap one destination at a time from the destination's own pending indication, which lets saved state be brought back after a bulk re-injection. A clear input empties the tracker at the start of such a re-injection. Only one operation takes effect per clock. The error output flags a delivery recorded while acknowledgements are still owed, and it also flags any decrement that would take the counter below zero.

Top module: `eoi_trk`

## Requirements
- R1: After a synchronous active-low reset, pend_cnt_o is 0, err_o is 0 and coalesced_o is 0.
- R2: coalesced_o is combinational and equals query_i AND (pend_cnt_o != 0), in the same cycle as the query.
- R3: A delivery (dlv_valid_i) taken while pend_cnt_o is 0 loads the bitmap with dlv_accept_i, where bit i is 1 when destination i accepted. pend_cnt_o then shows the number of 1 bits after the next rising edge.
- R4: A delivery taken while pend_cnt_o is non-zero leaves the bitmap and the count unchanged, and it raises err_o after the next rising edge.
- R5: An acknowledgement from destination eoi_dest_i clears that destination's bit and lowers the count by one, but only if the bit was set. Otherwise it changes nothing.
- R6: clear_i empties the bitmap and sets the count to 0 after the next rising edge.
- R7: A restore for destination rst_dest_i with rst_tgt_i high works as follows. If rst_pend_i is 1 and the bit is clear, the bit is set and the count rises by one. If rst_pend_i is 0 and the bit is set, the bit is cleared and the count falls by one. If the two already agree, nothing changes. With rst_tgt_i low, the restore changes nothing.
- R8: At most one operation acts per cycle, in this priority: clear, then delivery, then acknowledgement, then restore. Lower-priority requests in the same cycle are dropped.
- R9: The count always equals the number of set bits in the bitmap. A decrement at count 0 leaves the count at 0 and raises err_o.
- R10: err_o is a registered pulse. It is 0 in any cycle that follows a cycle with no error condition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clear_i | input | 1 | Empty the tracker (start of bulk re-injection) |
| dlv_valid_i | input | 1 | Record a delivery this cycle |
| dlv_accept_i | input | NUM_DEST | Destinations that accepted the delivery |
| eoi_valid_i | input | 1 | Acknowledgement arrives this cycle |
| eoi_dest_i | input | DEST_W | Index of the acknowledging destination |
| rst_valid_i | input | 1 | Restore one destination this cycle |
| rst_dest_i | input | DEST_W | Destination being restored |
| rst_tgt_i | input | 1 | Destination is targeted by the line's entry |
| rst_pend_i | input | 1 | Destination still owes an acknowledgement |
| query_i | input | 1 | Ask whether a new assertion would be coalesced |
| coalesced_o | output | 1 | New assertion must be treated as coalesced |
| pend_cnt_o | output | CNT_W | Number of acknowledgements still owed |
| err_o | output | 1 | Delivery while busy, or count underflow |

## Verification
coalesced_o is combinational, so the bench checks it after a short settle in the same cycle it drives query_i, and compares it against the count the model holds before the edge. The count and err_o both come from registers and are due one rising edge after the request. The bench therefore drives every request at a falling edge, updates its queue-free behavioural model at the rising edge, and compares both outputs at the following falling edge. Same-cycle collisions and restores that agree, are untargeted, or hit an empty bit are driven on purpose, and for each the count is checked to show that nothing changed.

// File: rtl/eoi_trk_pkg.sv
// Shared types for the acknowledgement tracker.
// Assumes: at most one operation acts per cycle, picked by eoi_trk_arb.
package eoi_trk_pkg;
    typedef enum logic [2:0] {
        OP_IDLE,
        OP_CLEAR,
        OP_LOAD,
        OP_ACK,
        OP_SYNC
    } trk_op_e;
endpackage

// File: rtl/eoi_trk_arb.sv
// Fixed-priority selector for the tracker operation of this cycle.
// Assumes: requests are single-cycle strobes; losers are dropped, not queued.
module eoi_trk_arb
    import eoi_trk_pkg::*;
(
    input  logic    clear_i,
    input  logic    dlv_i,
    input  logic    eoi_i,
    input  logic    sync_i,
    output trk_op_e op_o
);
    // Pick one operation: clear > delivery > acknowledgement > restore.
    always_comb begin
        if (clear_i)      op_o = OP_CLEAR;
        else if (dlv_i)   op_o = OP_LOAD;
        else if (eoi_i)   op_o = OP_ACK;
        else if (sync_i)  op_o = OP_SYNC;
        else              op_o = OP_IDLE;
    end
endmodule

// File: rtl/eoi_trk_map.sv
// Bitmap of destinations that still owe an acknowledgement.
// Assumes: load_ok_i is computed from the count so that a busy load is refused.
// Reports increment/decrement strobes so the counter stays in step with the bits.
module eoi_trk_map
    import eoi_trk_pkg::*;
#(
    parameter int NUM_DEST = 8,
    parameter int DEST_W   = (NUM_DEST > 1) ? $clog2(NUM_DEST) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  trk_op_e             op_i,
    input  logic                load_ok_i,
    input  logic [NUM_DEST-1:0] accept_i,
    input  logic [DEST_W-1:0]   ack_dest_i,
    input  logic [DEST_W-1:0]   sync_dest_i,
    input  logic                sync_tgt_i,
    input  logic                sync_pend_i,
    output logic [NUM_DEST-1:0] map_o,
    output logic                inc_o,
    output logic                dec_o
);
    logic [NUM_DEST-1:0] ack_sel;
    logic [NUM_DEST-1:0] sync_sel;

    for (genvar i = 0; i < NUM_DEST; i++) begin : g_bit
        // Decode which bit the acknowledgement or restore addresses.
        always_comb begin
            ack_sel[i]  = (op_i == OP_ACK) && (ack_dest_i == DEST_W'(i));
            sync_sel[i] = (op_i == OP_SYNC) && sync_tgt_i && (sync_dest_i == DEST_W'(i));
        end

        // Hold one destination's pending flag.
        always_ff @(posedge clk) begin
            if (!rst_n)                         map_o[i] <= 1'b0;
            else if (op_i == OP_CLEAR)          map_o[i] <= 1'b0;
            else if (op_i == OP_LOAD && load_ok_i) map_o[i] <= accept_i[i];
            else if (ack_sel[i])                map_o[i] <= 1'b0;
            else if (sync_sel[i])               map_o[i] <= sync_pend_i;
        end
    end

    // Tell the counter when a single bit actually flips.
    always_comb begin
        inc_o = (|(sync_sel & ~map_o)) && sync_pend_i;
        dec_o = (|(ack_sel & map_o)) || ((|(sync_sel & map_o)) && !sync_pend_i);
    end
endmodule

// File: rtl/eoi_trk_cnt.sv
// Counter of outstanding acknowledgements.
// Assumes: inc and dec are never both high (they come from one operation).
// A decrement at zero saturates and is reported on uflow_o.
module eoi_trk_cnt
    import eoi_trk_pkg::*;
#(
    parameter int NUM_DEST = 8,
    parameter int CNT_W    = $clog2(NUM_DEST + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  trk_op_e             op_i,
    input  logic                load_ok_i,
    input  logic [NUM_DEST-1:0] accept_i,
    input  logic                inc_i,
    input  logic                dec_i,
    output logic [CNT_W-1:0]    cnt_o,
    output logic                uflow_o
);
    logic [CNT_W-1:0] pop;

    // Count the destinations that accepted a delivery.
    always_comb begin
        pop = '0;
        for (int i = 0; i < NUM_DEST; i++) pop = pop + CNT_W'(accept_i[i]);
    end

    // Flag a decrement that would go below zero.
    always_comb uflow_o = dec_i && (cnt_o == '0);

    // Update the outstanding count.
    always_ff @(posedge clk) begin
        if (!rst_n)                            cnt_o <= '0;
        else if (op_i == OP_CLEAR)             cnt_o <= '0;
        else if (op_i == OP_LOAD && load_ok_i) cnt_o <= pop;
        else if (inc_i)                        cnt_o <= cnt_o + CNT_W'(1);
        else if (dec_i && !uflow_o)            cnt_o <= cnt_o - CNT_W'(1);
    end
endmodule

// File: rtl/eoi_trk.sv
// Top of the acknowledgement tracker for one edge-triggered line.
// Assumes: one operation per cycle (priority in eoi_trk_arb); destination
// indices at or above NUM_DEST match no bit and are therefore ignored.
module eoi_trk
    import eoi_trk_pkg::*;
#(
    parameter int NUM_DEST = 8,
    localparam int DEST_W  = (NUM_DEST > 1) ? $clog2(NUM_DEST) : 1,
    localparam int CNT_W   = $clog2(NUM_DEST + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clear_i,
    input  logic                dlv_valid_i,
    input  logic [NUM_DEST-1:0] dlv_accept_i,
    input  logic                eoi_valid_i,
    input  logic [DEST_W-1:0]   eoi_dest_i,
    input  logic                rst_valid_i,
    input  logic [DEST_W-1:0]   rst_dest_i,
    input  logic                rst_tgt_i,
    input  logic                rst_pend_i,
    input  logic                query_i,
    output logic                coalesced_o,
    output logic [CNT_W-1:0]    pend_cnt_o,
    output logic                err_o
);
    trk_op_e             op;
    logic                load_ok;
    logic                inc;
    logic                dec;
    logic                uflow;
    logic [NUM_DEST-1:0] pend_map;

    eoi_trk_arb u_arb (
        .clear_i (clear_i),
        .dlv_i   (dlv_valid_i),
        .eoi_i   (eoi_valid_i),
        .sync_i  (rst_valid_i),
        .op_o    (op)
    );

    eoi_trk_map #(.NUM_DEST(NUM_DEST), .DEST_W(DEST_W)) u_map (
        .clk         (clk),
        .rst_n       (rst_n),
        .op_i        (op),
        .load_ok_i   (load_ok),
        .accept_i    (dlv_accept_i),
        .ack_dest_i  (eoi_dest_i),
        .sync_dest_i (rst_dest_i),
        .sync_tgt_i  (rst_tgt_i),
        .sync_pend_i (rst_pend_i),
        .map_o       (pend_map),
        .inc_o       (inc),
        .dec_o       (dec)
    );

    eoi_trk_cnt #(.NUM_DEST(NUM_DEST), .CNT_W(CNT_W)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .op_i      (op),
        .load_ok_i (load_ok),
        .accept_i  (dlv_accept_i),
        .inc_i     (inc),
        .dec_i     (dec),
        .cnt_o     (pend_cnt_o),
        .uflow_o   (uflow)
    );

    // A delivery may only be recorded while nothing is owed.
    always_comb load_ok = (pend_cnt_o == '0);

    // Answer the coalesce query from the current count.
    always_comb coalesced_o = query_i && (pend_cnt_o != '0);

    // Register the error pulse for a busy delivery or an underflow.
    always_ff @(posedge clk) begin
        if (!rst_n) err_o <= 1'b0;
        else        err_o <= ((op == OP_LOAD) && !load_ok) || uflow;
    end
endmodule

// File: rtl/eoi_trk_chk.sv
// Property checker for eoi_trk, bound to every instance of the top.
// Assumes: it sees the internal bitmap through the bind connection.
module eoi_trk_chk #(
    parameter int NUM_DEST = 8,
    localparam int DEST_W  = (NUM_DEST > 1) ? $clog2(NUM_DEST) : 1,
    localparam int CNT_W   = $clog2(NUM_DEST + 1)
) (
    input logic                clk,
    input logic                rst_n,
    input logic                clear_i,
    input logic                dlv_valid_i,
    input logic [NUM_DEST-1:0] dlv_accept_i,
    input logic                eoi_valid_i,
    input logic [DEST_W-1:0]   eoi_dest_i,
    input logic                query_i,
    input logic                coalesced_o,
    input logic [CNT_W-1:0]    pend_cnt_o,
    input logic                err_o,
    input logic [NUM_DEST-1:0] map
);
    assert_cnt_tracks_map_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(map) == int'(pend_cnt_o));

    assert_coalesce_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (query_i && pend_cnt_o != '0) |-> coalesced_o);

    assert_coalesce_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_cnt_o == '0) |-> !coalesced_o);

    assert_clear_empties_R6: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> (pend_cnt_o == '0));

    assert_load_copies_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear_i && dlv_valid_i && pend_cnt_o == '0) |=> (map == $past(dlv_accept_i)));

    assert_busy_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear_i && dlv_valid_i && pend_cnt_o != '0) |=> (err_o && $stable(map)));

    assert_ack_drops_one_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear_i && !dlv_valid_i && eoi_valid_i && map[eoi_dest_i])
        |=> (pend_cnt_o == $past(pend_cnt_o) - CNT_W'(1)));
endmodule

bind eoi_trk eoi_trk_chk #(.NUM_DEST(NUM_DEST)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .clear_i      (clear_i),
    .dlv_valid_i  (dlv_valid_i),
    .dlv_accept_i (dlv_accept_i),
    .eoi_valid_i  (eoi_valid_i),
    .eoi_dest_i   (eoi_dest_i),
    .query_i      (query_i),
    .coalesced_o  (coalesced_o),
    .pend_cnt_o   (pend_cnt_o),
    .err_o        (err_o),
    .map          (pend_map)
);

// File: tb/tb_eoi_trk.sv
// Self-checking bench: a behavioural model is stepped every clock and
// compared with the outputs at the falling edge after each rising edge.
module tb_eoi_trk;
    localparam int M  = 8;
    localparam int DW = 3;
    localparam int CW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          clear_i = 1'b0;
    logic          dlv_valid_i = 1'b0;
    logic [M-1:0]  dlv_accept_i = '0;
    logic          eoi_valid_i = 1'b0;
    logic [DW-1:0] eoi_dest_i = '0;
    logic          rst_valid_i = 1'b0;
    logic [DW-1:0] rst_dest_i = '0;
    logic          rst_tgt_i = 1'b0;
    logic          rst_pend_i = 1'b0;
    logic          query_i = 1'b0;
    logic          coalesced_o;
    logic [CW-1:0] pend_cnt_o;
    logic          err_o;

    int  n_chk = 0;
    int  n_err = 0;
    bit  done = 1'b0;
    bit  mmap [M];
    int  mcnt = 0;
    bit  merr = 1'b0;

    always #5 clk = ~clk;

    eoi_trk #(.NUM_DEST(M)) dut (
        .clk(clk), .rst_n(rst_n), .clear_i(clear_i),
        .dlv_valid_i(dlv_valid_i), .dlv_accept_i(dlv_accept_i),
        .eoi_valid_i(eoi_valid_i), .eoi_dest_i(eoi_dest_i),
        .rst_valid_i(rst_valid_i), .rst_dest_i(rst_dest_i),
        .rst_tgt_i(rst_tgt_i), .rst_pend_i(rst_pend_i),
        .query_i(query_i), .coalesced_o(coalesced_o),
        .pend_cnt_o(pend_cnt_o), .err_o(err_o)
    );

    task automatic chk(input string tag, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // Behavioural next state from the requests now on the inputs.
    task automatic model_step();
        merr = 1'b0;
        if (clear_i) begin
            foreach (mmap[i]) mmap[i] = 1'b0;
            mcnt = 0;
        end else if (dlv_valid_i) begin
            if (mcnt == 0) begin
                foreach (mmap[i]) begin
                    mmap[i] = dlv_accept_i[i];
                    if (dlv_accept_i[i]) mcnt++;
                end
            end else merr = 1'b1;
        end else if (eoi_valid_i) begin
            if (mmap[eoi_dest_i]) begin
                mmap[eoi_dest_i] = 1'b0;
                mcnt--;
            end
        end else if (rst_valid_i && rst_tgt_i) begin
            if (rst_pend_i && !mmap[rst_dest_i]) begin
                mmap[rst_dest_i] = 1'b1;
                mcnt++;
            end else if (!rst_pend_i && mmap[rst_dest_i]) begin
                mmap[rst_dest_i] = 1'b0;
                mcnt--;
            end
        end
    endtask

    // One clock: check the combinational flag, advance, check registered outputs.
    task automatic tick(input string tag);
        #1;
        chk("R2", "coalesced_o", int'(coalesced_o), int'(query_i && mcnt > 0));
        model_step();
        @(posedge clk);
        @(negedge clk);
        chk(tag, "pend_cnt_o", int'(pend_cnt_o), mcnt);
        chk("R10", "err_o", int'(err_o), int'(merr));
        clear_i = 1'b0; dlv_valid_i = 1'b0; eoi_valid_i = 1'b0;
        rst_valid_i = 1'b0; query_i = 1'b0; rst_tgt_i = 1'b0; rst_pend_i = 1'b0;
    endtask

    task automatic ack(input int d, input string tag);
        eoi_valid_i = 1'b1; eoi_dest_i = DW'(d); tick(tag);
    endtask

    task automatic sync(input int d, input bit tgt, input bit pend, input string tag);
        rst_valid_i = 1'b1; rst_dest_i = DW'(d); rst_tgt_i = tgt; rst_pend_i = pend;
        tick(tag);
    endtask

    task automatic deliver(input logic [M-1:0] acc, input string tag);
        dlv_valid_i = 1'b1; dlv_accept_i = acc; tick(tag);
    endtask

    initial begin
        foreach (mmap[i]) mmap[i] = 1'b0;
        repeat (3) @(negedge clk);
        query_i = 1'b1;
        #1;
        chk("R1", "pend_cnt_o", int'(pend_cnt_o), 0);
        chk("R1", "err_o", int'(err_o), 0);
        chk("R1", "coalesced_o", int'(coalesced_o), 0);
        query_i = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);

        deliver(8'b1011_0010, "R3");                 // four acceptors
        query_i = 1'b1; tick("R2");                   // busy -> coalesced
        deliver(8'b0000_0001, "R4");                  // refused, error pulse
        chk("R4", "err_o", int'(err_o), 1);
        tick("R10");                                  // pulse gone

        ack(0, "R5");                                 // bit clear: no effect
        ack(1, "R5");                                 // 4 -> 3
        ack(1, "R5");                                 // repeat: no effect

        sync(0, 1'b1, 1'b1, "R7");                    // set bit 0: 3 -> 4
        sync(0, 1'b1, 1'b1, "R7");                    // agree: no change
        sync(4, 1'b1, 1'b0, "R7");                    // clear bit 4: 4 -> 3
        sync(2, 1'b0, 1'b1, "R7");                    // not targeted: no change
        sync(2, 1'b1, 1'b0, "R7");                    // agree (both clear)

        eoi_valid_i = 1'b1; eoi_dest_i = 3'd5;        // ack wins over restore
        rst_valid_i = 1'b1; rst_dest_i = 3'd6; rst_tgt_i = 1'b1; rst_pend_i = 1'b1;
        tick("R8");

        clear_i = 1'b1; dlv_valid_i = 1'b1; dlv_accept_i = 8'hFF;
        tick("R6");                                   // clear wins
        chk("R8", "pend_cnt_o", int'(pend_cnt_o), 0);

        query_i = 1'b1; tick("R2");                   // idle -> not coalesced
        deliver(8'h00, "R3");                         // zero acceptors
        deliver(8'h41, "R3");
        dlv_valid_i = 1'b1; dlv_accept_i = 8'hFF; eoi_valid_i = 1'b1; eoi_dest_i = 3'd0;
        tick("R8");                                   // busy load beats ack
        ack(6, "R5");
        ack(0, "R5");
        deliver(8'hFF, "R3");                         // full house
        for (int d = 0; d < M; d++) ack(d, "R9");     // drain to zero
        sync(3, 1'b1, 1'b0, "R9");                    // nothing to drop
        sync(3, 1'b1, 1'b1, "R7");
        clear_i = 1'b1; tick("R6");

        rst_n = 1'b0; tick("R1");
        rst_n = 1'b1;
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++; n_err++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end
endmodule